// File: doc/BRIEF.md
# Byte-to-Doubleword Burst Buffer

This block is the data buffer of a burst-mode subchannel. On one side a device moves data one byte at a time through a valid/ready strobe. On the other side a shared main controller moves data one 64-bit doubleword at a time, in exchanges that the block requests and the controller grants. In the input direction, device bytes are packed into doublewords and handed to the controller. In the output direction, doublewords from the controller are unpacked into a byte stream for the device.

Two doubleword registers work in alternation. While one register is exchanged with the controller, the device side keeps working on the other one. A lane counter picks the byte position that the device side touches. A remaining-byte counter stops the transfer on the exact programmed length, even when that length ends inside a doubleword. When an input transfer ends inside a doubleword, the partly filled doubleword is handed over with a byte-valid mask.

Requests come in two classes. The urgent class stores a filled input doubleword, or refills an output register after it has drained. The lower class fetches the first doublewords of an output transfer in advance, before the device asks for any data.

Top module: `burst_dw_buffer`

## Requirements
- R1: After reset, `busy`, `done`, `req_pri`, `req_sec`, `in_rdy` and `out_vld` are all low.
- R2: In the input direction, byte k of each doubleword, counted in arrival order from 0, is placed in bits [63-8k -: 8] of `ctl_wdata`. The first byte therefore lands in the most significant byte.
- R3: When an input doubleword holds 8 bytes, `req_pri` rises. During the grant cycle the block presents that doubleword on `ctl_wdata` with `ctl_wmask` = 8'hFF.
- R4: An input transfer of `xfer_len` bytes accepts exactly that many bytes, and `in_rdy` stays low afterwards. A final doubleword holding m < 8 bytes is handed over with `ctl_wmask` bit i set for lanes i < m only.
- R5: The device side can fill the second register while the first waits for its grant. `in_rdy` goes low only when both registers hold unexchanged data. A register that still holds data is never overwritten.
- R6: A request stays high, with the same class, until `grant` is seen. It is low in the cycle after the grant.
- R7: In the output direction, the first min(2, ceil(len/8)) fetches use `req_sec` and every later fetch uses `req_pri`. Input flushes always use `req_pri`. The two request lines are never high together.
- R8: In the output direction, exactly `xfer_len` bytes are produced on `out_byte`. They are taken from each fetched doubleword from bits [63:56] downward, in fetch order.
- R9: `done` is a one-cycle pulse with `busy` low. It follows the last byte taken (output) or the last doubleword exchanged (input).
- R10: A `start` pulse while `busy` is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_out | input | 1 | 1 = output to device, 0 = input from device |
| xfer_len | input | LEN_W | Number of bytes to transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| in_byte | input | 8 | Byte from device |
| in_vld | input | 1 | Device byte valid |
| in_rdy | output | 1 | Block accepts device byte |
| out_byte | output | 8 | Byte to device |
| out_vld | output | 1 | Output byte valid |
| out_rdy | input | 1 | Device takes output byte |
| req_pri | output | 1 | Urgent exchange request |
| req_sec | output | 1 | Prefetch exchange request |
| grant | input | 1 | Controller performs the exchange this cycle |
| ctl_wdata | output | 64 | Doubleword handed to controller |
| ctl_wmask | output | 8 | Byte-valid mask, bit i = lane i |
| ctl_rdata | input | 64 | Doubleword supplied by controller |

## Verification
The input path runs three ways. A full 24-byte transfer with a slow grant fills both registers, so the stall point shows whether the second register really overlaps the pending exchange. An 11-byte transfer ends inside a doubleword, which tells a correct lane mask and stop point apart from an overrun. The output path runs with 19 bytes and with 5 bytes. This shows whether requests switch from the prefetch class to the urgent class after the first two fetches, and whether a single short fetch stays in the prefetch class. A start pulse issued during a 10-byte output shows whether a running transfer can be disturbed.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG   = 2;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } dir_e;
endpackage

// File: rtl/bb_req_ctl.sv
module bb_req_ctl (
  input  logic clk,
  input  logic rst,
  input  logic need,
  input  logic need_sec,
  input  logic grant,
  output logic req_pri,
  output logic req_sec,
  output logic xchg
);
  assign xchg = grant && (req_pri || req_sec);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_pri <= 1'b0;
      req_sec <= 1'b0;
    end else if (xchg) begin
      req_pri <= 1'b0;
      req_sec <= 1'b0;
    end else if (need && !req_pri && !req_sec) begin
      req_pri <= !need_sec;
      req_sec <= need_sec;
    end
  end

  // R6
  pri_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_pri && !grant) |=> req_pri);
  // R6
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_sec && !grant) |=> req_sec);
  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    xchg |=> !(req_pri || req_sec));
  // R7
  req_class_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_pri && req_sec));
endmodule

// File: rtl/bb_byte_ctr.sv
module bb_byte_ctr #(
  parameter int LEN_W  = 16,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [LEN_W-1:0]  left,
  output logic [LANE_W-1:0] lane,
  output logic              last,
  output logic              lane_end
);
  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      lane <= '0;
    end else if (load) begin
      left <= len;
      lane <= '0;
    end else if (step) begin
      left <= left - 1'b1;
      lane <= lane + 1'b1;
    end
  end

  assign last     = (left == LEN_W'(1));
  assign lane_end = &lane;

  // R4
  step_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (left != '0));
endmodule

// File: rtl/bb_dw_bank.sv
module bb_dw_bank
  import bb_pkg::*;
#(
  parameter int DW_BYTES = 8,
  localparam int DW_W    = DW_BYTES * BYTE_W,
  localparam int LANE_W  = $clog2(DW_BYTES),
  localparam int SEL_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DW_W-1:0]   ld_data,
  input  logic              seal_en,
  input  logic [SEL_W-1:0]  seal_sel,
  input  logic              clr_en,
  input  logic [SEL_W-1:0]  clr_sel,
  output logic [DW_W-1:0]   data [NREG],
  output logic [DW_BYTES-1:0] mask [NREG],
  output logic [NREG-1:0]   full
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (ld_en && ld_sel == SEL_W'(g)) begin
        data[g] <= ld_data;
      end else if (wr_en && wr_sel == SEL_W'(g)) begin
        data[g][DW_W-1-BYTE_W*wr_lane -: BYTE_W] <= wr_byte;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        full[g] <= 1'b0;
        mask[g] <= '0;
      end else if (clr_en && clr_sel == SEL_W'(g)) begin
        full[g] <= 1'b0;
        mask[g] <= '0;
      end else if (ld_en && ld_sel == SEL_W'(g)) begin
        full[g] <= 1'b1;
        mask[g] <= '1;
      end else begin
        if (wr_en && wr_sel == SEL_W'(g)) mask[g][wr_lane] <= 1'b1;
        if (seal_en && seal_sel == SEL_W'(g)) full[g] <= 1'b1;
      end
    end
  end

  // R5
  no_overwrite_ld_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> !full[ld_sel]);
  // R5
  no_overwrite_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full[wr_sel]);
endmodule

// File: rtl/burst_dw_buffer.sv
module burst_dw_buffer
  import bb_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int DW_BYTES    = 8,
  parameter int PREFETCH_DW = 2,
  localparam int DW_W       = DW_BYTES * BYTE_W,
  localparam int LANE_W     = $clog2(DW_BYTES),
  localparam int SEL_W      = $clog2(NREG),
  localparam int PF_W       = $clog2(PREFETCH_DW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_out,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              done,
  input  logic [7:0]        in_byte,
  input  logic              in_vld,
  output logic              in_rdy,
  output logic [7:0]        out_byte,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic              req_pri,
  output logic              req_sec,
  input  logic              grant,
  output logic [DW_W-1:0]   ctl_wdata,
  output logic [DW_BYTES-1:0] ctl_wmask,
  input  logic [DW_W-1:0]   ctl_rdata
);
  dir_e             dir_q;
  logic             busy_q, done_q;
  logic [SEL_W-1:0] port_sel, ctl_sel;
  logic [LEN_W-1:0] fetch_left;
  logic [PF_W-1:0]  fetched;
  logic [LEN_W:0]   dw_total;

  logic [DW_W-1:0]     data [NREG];
  logic [DW_BYTES-1:0] mask [NREG];
  logic [NREG-1:0]     full;

  logic [LEN_W-1:0]  left;
  logic [LANE_W-1:0] lane;
  logic last, lane_end;
  logic need, need_sec, xchg;
  logic take_start, dev_ok, acc_in, acc_out, step, lane_done, finish;

  assign take_start = start && !busy_q;
  assign dw_total   = ({1'b0, xfer_len} + (LEN_W+1)'(DW_BYTES - 1)) >> LANE_W;

  assign dev_ok  = busy_q && (left != '0) &&
                   ((dir_q == DIR_OUT) ? full[port_sel] : !full[port_sel]);
  assign in_rdy  = dev_ok && (dir_q == DIR_IN);
  assign out_vld = dev_ok && (dir_q == DIR_OUT);
  assign acc_in  = in_rdy && in_vld;
  assign acc_out = out_vld && out_rdy;
  assign step    = acc_in || acc_out;
  assign lane_done = step && (lane_end || last);

  assign need = busy_q && ((dir_q == DIR_OUT) ?
                           ((fetch_left != '0) && !full[ctl_sel]) :
                           full[ctl_sel]);
  assign need_sec = (dir_q == DIR_OUT) && (fetched < PF_W'(PREFETCH_DW));

  assign finish = busy_q && (left == '0) &&
                  ((dir_q == DIR_OUT) || (full == '0));

  bb_byte_ctr #(.LEN_W(LEN_W), .LANE_W(LANE_W)) u_ctr (
    .clk(clk), .rst(rst), .load(take_start), .len(xfer_len), .step(step),
    .left(left), .lane(lane), .last(last), .lane_end(lane_end)
  );

  bb_req_ctl u_req (
    .clk(clk), .rst(rst), .need(need), .need_sec(need_sec), .grant(grant),
    .req_pri(req_pri), .req_sec(req_sec), .xchg(xchg)
  );

  bb_dw_bank #(.DW_BYTES(DW_BYTES)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(acc_in), .wr_sel(port_sel), .wr_lane(lane), .wr_byte(in_byte),
    .ld_en(xchg && dir_q == DIR_OUT), .ld_sel(ctl_sel), .ld_data(ctl_rdata),
    .seal_en(lane_done && dir_q == DIR_IN), .seal_sel(port_sel),
    .clr_en((xchg && dir_q == DIR_IN) || (lane_done && dir_q == DIR_OUT)),
    .clr_sel((dir_q == DIR_OUT) ? port_sel : ctl_sel),
    .data(data), .mask(mask), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      dir_q      <= DIR_IN;
      port_sel   <= '0;
      ctl_sel    <= '0;
      fetch_left <= '0;
      fetched    <= '0;
    end else begin
      done_q <= 1'b0;
      if (take_start) begin
        busy_q     <= 1'b1;
        dir_q      <= dir_out ? DIR_OUT : DIR_IN;
        port_sel   <= '0;
        ctl_sel    <= '0;
        fetch_left <= dw_total[LEN_W-1:0];
        fetched    <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        if (lane_done) port_sel <= port_sel + 1'b1;
        if (xchg) begin
          ctl_sel <= ctl_sel + 1'b1;
          if (dir_q == DIR_OUT) begin
            fetch_left <= fetch_left - 1'b1;
            if (fetched < PF_W'(PREFETCH_DW)) fetched <= fetched + 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign out_byte  = data[port_sel][DW_W-1-BYTE_W*lane -: BYTE_W];
  assign ctl_wdata = data[ctl_sel];
  assign ctl_wmask = mask[ctl_sel];

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  in_flush_pri_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && dir_q == DIR_IN) |-> !req_sec);
endmodule

// File: tb/test_burst_dw_buffer.sv
module test_burst_dw_buffer;
  logic clk = 0, rst = 1;
  logic start = 0, dir_out = 0;
  logic [15:0] xfer_len = '0;
  logic busy, done;
  logic [7:0] in_byte = '0;
  logic in_vld = 0, in_rdy;
  logic [7:0] out_byte;
  logic out_vld, out_rdy = 0;
  logic req_pri, req_sec, grant;
  logic [63:0] ctl_wdata, ctl_rdata;
  logic [7:0] ctl_wmask;

  int n_chk = 0, n_fail = 0;
  int gnt_lat = 0, wait_cnt = 0, n_gnt = 0, n_rx = 0;
  logic [63:0] cap_data [0:15];
  logic [7:0]  cap_mask [0:15];
  logic        cls_sec  [0:15];
  logic [7:0]  rx [0:63];

  always #4 clk = ~clk;

  burst_dw_buffer i_burst_dw_buffer (
    .clk(clk), .rst(rst), .start(start), .dir_out(dir_out), .xfer_len(xfer_len),
    .busy(busy), .done(done), .in_byte(in_byte), .in_vld(in_vld), .in_rdy(in_rdy),
    .out_byte(out_byte), .out_vld(out_vld), .out_rdy(out_rdy),
    .req_pri(req_pri), .req_sec(req_sec), .grant(grant),
    .ctl_wdata(ctl_wdata), .ctl_wmask(ctl_wmask), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] in_dw(input logic [7:0] base, input int n);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[63-8*k -: 8] = base + 8'(k);
    return r;
  endfunction

  function automatic logic [63:0] src_dw(input int i);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[63-8*k -: 8] = 8'((i << 4) | k);
    return r;
  endfunction

  // controller model
  initial begin
    grant = 0; ctl_rdata = '0;
    forever begin
      @(negedge clk);
      if (grant) begin
        grant = 0;
        // R6: request low in the cycle after the grant
        chk(!(req_pri || req_sec), "R6 req after grant", {62'd0, req_pri, req_sec}, 64'd0);
      end else if ((req_pri || req_sec) && !rst) begin
        if (wait_cnt < gnt_lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          grant = 1;
          if (n_gnt < 16) begin
            cap_data[n_gnt] = ctl_wdata;
            cap_mask[n_gnt] = ctl_wmask;
            cls_sec[n_gnt]  = req_sec;
          end
          ctl_rdata = src_dw(n_gnt);
          n_gnt++;
        end
      end
    end
  end

  // output byte monitor
  initial forever begin
    @(negedge clk);
    if (out_vld && out_rdy) begin
      if (n_rx < 64) rx[n_rx] = out_byte;
      n_rx++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic clear_log();
    n_gnt = 0; n_rx = 0; wait_cnt = 0;
  endtask

  task automatic start_op(input logic d, input int len);
    @(negedge clk);
    start = 1; dir_out = d; xfer_len = 16'(len);
    @(negedge clk);
    start = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_byte = b; in_vld = 1;
    #1;
    while (!in_rdy) begin @(negedge clk); #1; end
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R9 done seen", {63'd0, done}, 64'd1);
    chk(busy === 1'b0, "R9 busy low with done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single pulse", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !req_pri && !req_sec && !in_rdy && !out_vld, "R1 reset state",
        {58'd0, busy, done, req_pri, req_sec, in_rdy, out_vld}, 64'd0);
  endtask

  task automatic t_in_full();
    clear_log(); gnt_lat = 30;
    start_op(0, 24);
    for (int k = 0; k < 16; k++) send_byte(8'h30 + 8'(k));
    #1;
    chk(in_rdy === 1'b0, "R5 stall with both full", {63'd0, in_rdy}, 64'd0);
    chk(n_gnt == 0, "R5 second register filled before grant", 64'(n_gnt), 64'd0);
    chk(req_pri && !req_sec, "R3 primary request held", {62'd0, req_pri, req_sec}, 64'd2);
    gnt_lat = 1;
    for (int k = 16; k < 24; k++) send_byte(8'h30 + 8'(k));
    wait_done();
    chk(n_gnt == 3, "R3 three doublewords flushed", 64'(n_gnt), 64'd3);
    chk(cap_data[0] == in_dw(8'h30, 8), "R2 first doubleword order", cap_data[0], in_dw(8'h30, 8));
    chk(cap_data[2] == in_dw(8'h40, 8), "R2 third doubleword order", cap_data[2], in_dw(8'h40, 8));
    chk(cap_mask[0] == 8'hFF && cap_mask[2] == 8'hFF, "R3 full mask",
        {48'd0, cap_mask[0], cap_mask[2]}, 64'hFFFF);
    chk(!cls_sec[0] && !cls_sec[1] && !cls_sec[2], "R7 input uses primary",
        {61'd0, cls_sec[0], cls_sec[1], cls_sec[2]}, 64'd0);
  endtask

  task automatic t_in_part();
    clear_log(); gnt_lat = 2;
    start_op(0, 11);
    for (int k = 0; k < 11; k++) send_byte(8'h50 + 8'(k));
    #1;
    chk(in_rdy === 1'b0, "R4 no byte beyond length", {63'd0, in_rdy}, 64'd0);
    wait_done();
    chk(n_gnt == 2, "R4 two doublewords", 64'(n_gnt), 64'd2);
    chk(cap_data[0] == in_dw(8'h50, 8), "R2 packed order", cap_data[0], in_dw(8'h50, 8));
    chk(cap_mask[1] == 8'h07, "R4 partial mask", 64'(cap_mask[1]), 64'h07);
    chk(cap_data[1][63:40] == 24'h58595A, "R4 partial lanes", 64'(cap_data[1][63:40]), 64'h58595A);
  endtask

  task automatic t_out(input int len, input int exp_gnt);
    int bad = 0;
    clear_log(); gnt_lat = 1; out_rdy = 1;
    start_op(1, len);
    wait_done();
    chk(n_rx == len, "R8 byte count", 64'(n_rx), 64'(len));
    for (int k = 0; k < len && k < 64; k++)
      if (rx[k] !== 8'(((k >> 3) << 4) | (k & 7))) bad++;
    chk(bad == 0, "R8 byte order", 64'(bad), 64'd0);
    chk(n_gnt == exp_gnt, "R8 fetch count", 64'(n_gnt), 64'(exp_gnt));
    for (int i = 0; i < exp_gnt; i++)
      chk(cls_sec[i] == (i < 2), "R7 request class", 64'(cls_sec[i]), 64'(i < 2));
    chk(out_vld === 1'b0, "R8 no byte after end", {63'd0, out_vld}, 64'd0);
    out_rdy = 0;
  endtask

  task automatic t_busy_start();
    int bad = 0;
    clear_log(); gnt_lat = 3; out_rdy = 1;
    start_op(1, 10);
    repeat (2) @(negedge clk);
    start = 1; dir_out = 0; xfer_len = 16'd3;
    @(negedge clk);
    start = 0;
    #1;
    chk(in_rdy === 1'b0, "R10 direction unchanged", {63'd0, in_rdy}, 64'd0);
    wait_done();
    chk(n_rx == 10, "R10 length unchanged", 64'(n_rx), 64'd10);
    for (int k = 0; k < 10; k++)
      if (rx[k] !== 8'(((k >> 3) << 4) | (k & 7))) bad++;
    chk(bad == 0, "R10 data unchanged", 64'(bad), 64'd0);
    out_rdy = 0;
  endtask

  initial begin
    t_reset();
    t_in_full();
    t_in_part();
    t_out(19, 3);
    t_out(5, 1);
    t_busy_start();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule